// File: doc/BRIEF.md
# Sign-Sign LMS DFE Tap Estimator

This block adapts the main cursor (h0) and the post-cursor weights (h1 to hN) of a decision feedback equalizer, one unit interval per clock. Each cycle it takes the binary data decision of the current symbol and the signs of two error comparators that run side by side. One compares the summer output against +h0 and the other against -h0. The decision arrives too late to pick the comparator threshold, so both comparisons are made and the decision then selects the valid one. The selected error sign and the stored past decisions drive a sign-sign LMS update of a bank of saturating signed accumulators. The accumulators' upper bits form the tap weights. The main cursor is also exported on its own for front-end gain control.

The block has an unrolled first-tap mode. In that mode h1 is not in the feedback sum, so the front end aims its even-UI error comparators at the level where the current and previous symbols match and its odd-UI comparators at the level where they differ. Each error sample is used only when the data pattern fits the phase it came from. The step size is a power-of-two right shift, and an enable and a preset load control the adaptation.

Top module: `sslms_tap_adapt`

## Requirements
- R1: After reset every tap output and `h0_main` read zero, and every stored past decision reads as 0 (that is, -1).
- R2: The error sign in use is `err_pos_hi` when `dec_bit` is 1 and `err_neg_hi` when `dec_bit` is 0. The unused comparator has no effect on any tap.
- R3: Decisions map 1 to +1 and 0 to -1. On an update, tap n (n = 0..NTAP) moves up when the error sign equals the decision from n symbols earlier (n = 0 is the current decision) and moves down otherwise. The history shifts every cycle.
- R4: The step is 2^(FRAC_W - mu_shift) accumulator LSBs, and any `mu_shift` above FRAC_W acts as FRAC_W. Each tap output is the accumulator shifted right by FRAC_W (arithmetic).
- R5: Accumulators saturate at the signed maximum and minimum of ACC_W = TAP_W+FRAC_W bits and never wrap.
- R6: The h0 accumulator never goes below zero, both on update and on load.
- R7: With `adapt_en` low and `load_en` low, all taps hold their value.
- R8: `load_en` sets every accumulator to `init_tap` shifted left by FRAC_W on the next edge (h0 floored at zero). Load takes priority over `adapt_en`.
- R9: With `unroll_en` high, an update happens only on an even UI (`ui_odd`=0) whose decision equals the previous decision, or on an odd UI whose decision differs from it. Otherwise the taps hold. With `unroll_en` low, `ui_odd` has no effect.
- R10: `h0_main` always equals tap 0 of `tap_bank`. Tap n occupies bits [n*TAP_W +: TAP_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UI-rate clock |
| rst_n | input | 1 | Active-low reset |
| adapt_en | input | 1 | Allows tap updates |
| load_en | input | 1 | Presets all taps from init_tap |
| init_tap | input | TAP_W | Signed preset value |
| mu_shift | input | MU_W | Step-size right shift |
| unroll_en | input | 1 | Unrolled first-tap mode |
| ui_odd | input | 1 | Phase of the current UI (1 = odd) |
| dec_bit | input | 1 | Data decision of the current symbol |
| err_pos_hi | input | 1 | Summer output above +h0 |
| err_neg_hi | input | 1 | Summer output above -h0 |
| tap_bank | output | (NTAP+1)*TAP_W | Signed taps h0..hN, packed |
| h0_main | output | TAP_W | Main-cursor estimate for front-end gain |

## Verification
The bench drives both taps to positive saturation and to negative saturation. A design that wrapped would show a tap jump from +127 to -128. It also drives h0 down from zero, where a missing floor would show a negative main cursor, and it loads a negative preset. Random runs flip the unused comparator freely, so a design that picked the comparator by the wrong decision would drift away from the model. Unrolled-mode runs mix both phases with all four two-symbol patterns, and mu_shift values above FRAC_W check that the step clamps and does not drop to zero.

// File: rtl/sslms_pkg.sv
package sslms_pkg;

    typedef enum logic {
        STEP_DN = 1'b0,
        STEP_UP = 1'b1
    } step_dir_e;

    // sign-sign product: equal signs push the tap up
    function automatic step_dir_e dir_of(input logic err_sgn, input logic dec_sgn);
        return (err_sgn == dec_sgn) ? STEP_UP : STEP_DN;
    endfunction

endpackage

// File: rtl/sslms_dec_hist.sv
module sslms_dec_hist #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_i,
    output logic [DEPTH:1]   hist_o
);

    typedef struct packed {
        logic [DEPTH:1] sr;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sr[1] = dec_i;
        for (int n = 2; n <= DEPTH; n++) begin
            st_d.sr[n] = st_q.sr[n-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_o = st_q.sr;

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hist_o[1] == $past(dec_i))) else $error("history shift"); // R3

endmodule

// File: rtl/sslms_err_sel.sv
module sslms_err_sel (
    input  logic dec_i,
    input  logic prev_i,
    input  logic err_pos_i,
    input  logic err_neg_i,
    input  logic unroll_i,
    input  logic odd_i,
    output logic esign_o,
    output logic qual_o
);

    logic same_pat;

    always_comb begin
        esign_o  = dec_i ? err_pos_i : err_neg_i;
        same_pat = (dec_i == prev_i);
        if (!unroll_i) begin
            qual_o = 1'b1;
        end else if (odd_i) begin
            qual_o = !same_pat;
        end else begin
            qual_o = same_pat;
        end
    end

endmodule

// File: rtl/sslms_tap_cell.sv
module sslms_tap_cell #(
    parameter int TAP_W  = 8,
    parameter int FRAC_W = 6,
    parameter bit NONNEG = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [TAP_W-1:0]          init_i,
    input  logic                      upd_i,
    input  logic                      dir_i,
    input  logic [TAP_W+FRAC_W-1:0]   step_i,
    output logic [TAP_W-1:0]          tap_o
);

    localparam int ACC_W = TAP_W + FRAC_W;
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } cell_t;

    cell_t st_d, st_q;

    logic [ACC_W:0]   sum_ext;
    logic [ACC_W:0]   delta;
    logic [ACC_W-1:0] sat_val;
    logic [ACC_W-1:0] init_acc;

    always_comb begin
        delta   = dir_i ? {1'b0, step_i} : (~{1'b0, step_i} + 1'b1);
        sum_ext = {st_q.acc[ACC_W-1], st_q.acc} + delta;
        if (sum_ext[ACC_W] != sum_ext[ACC_W-1]) begin
            sat_val = sum_ext[ACC_W] ? ACC_MIN : ACC_MAX;
        end else begin
            sat_val = sum_ext[ACC_W-1:0];
        end
        if (NONNEG && sat_val[ACC_W-1]) begin
            sat_val = '0;
        end

        init_acc = {init_i, {FRAC_W{1'b0}}};
        if (NONNEG && init_i[TAP_W-1]) begin
            init_acc = '0;
        end

        st_d = st_q;
        if (load_i) begin
            st_d.acc = init_acc;
        end else if (upd_i) begin
            st_d.acc = sat_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tap_o = st_q.acc[ACC_W-1:FRAC_W];

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (($signed({st_q.acc[ACC_W-1], st_q.acc}) - $signed({$past(st_q.acc[ACC_W-1]), $past(st_q.acc)}))
                     <= $signed({1'b0, $past(step_i)}))
                 && (($signed({$past(st_q.acc[ACC_W-1]), $past(st_q.acc)}) - $signed({st_q.acc[ACC_W-1], st_q.acc}))
                     <= $signed({1'b0, $past(step_i)}))) else $error("step bound"); // R5

    AST_LOAD_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !(NONNEG && init_i[TAP_W-1])) |=> (tap_o == $past(init_i))) else $error("load value"); // R8

    generate
        if (NONNEG) begin : g_floor
            AST_H0_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> !tap_o[TAP_W-1]) else $error("h0 negative"); // R6
        end
    endgenerate

endmodule

// File: rtl/sslms_tap_adapt.sv
module sslms_tap_adapt #(
    parameter int NTAP   = 4,
    parameter int TAP_W  = 8,
    parameter int FRAC_W = 6,
    parameter int MU_W   = $clog2(FRAC_W + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adapt_en,
    input  logic                       load_en,
    input  logic [TAP_W-1:0]           init_tap,
    input  logic [MU_W-1:0]            mu_shift,
    input  logic                       unroll_en,
    input  logic                       ui_odd,
    input  logic                       dec_bit,
    input  logic                       err_pos_hi,
    input  logic                       err_neg_hi,
    output logic [(NTAP+1)*TAP_W-1:0]  tap_bank,
    output logic [TAP_W-1:0]           h0_main
);

    import sslms_pkg::*;

    localparam int ACC_W = TAP_W + FRAC_W;
    localparam logic [MU_W-1:0] MU_LIM = MU_W'(FRAC_W);

    typedef struct packed {
        logic [NTAP:0]    dir;
        logic             upd;
        logic [ACC_W-1:0] step;
    } ctrl_t;

    ctrl_t            ctl_d;
    logic [NTAP:1]    hist;
    logic [NTAP:0]    a_vec;
    logic             esign;
    logic             qual;
    logic [MU_W-1:0]  mu_eff;

    sslms_dec_hist #(.DEPTH(NTAP)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec_i  (dec_bit),
        .hist_o (hist)
    );

    sslms_err_sel u_sel (
        .dec_i     (dec_bit),
        .prev_i    (hist[1]),
        .err_pos_i (err_pos_hi),
        .err_neg_i (err_neg_hi),
        .unroll_i  (unroll_en),
        .odd_i     (ui_odd),
        .esign_o   (esign),
        .qual_o    (qual)
    );

    always_comb begin
        a_vec  = {hist, dec_bit};
        mu_eff = (mu_shift > MU_LIM) ? MU_LIM : mu_shift;
        ctl_d.step = {{(ACC_W-1){1'b0}}, 1'b1} << (MU_LIM - mu_eff);
        ctl_d.upd  = adapt_en && qual;
        for (int n = 0; n <= NTAP; n++) begin
            ctl_d.dir[n] = (dir_of(esign, a_vec[n]) == STEP_UP);
        end
    end

    generate
        for (genvar n = 0; n <= NTAP; n++) begin : g_tap
            sslms_tap_cell #(
                .TAP_W  (TAP_W),
                .FRAC_W (FRAC_W),
                .NONNEG (n == 0)
            ) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_i (load_en),
                .init_i (init_tap),
                .upd_i  (ctl_d.upd),
                .dir_i  (ctl_d.dir[n]),
                .step_i (ctl_d.step),
                .tap_o  (tap_bank[n*TAP_W +: TAP_W])
            );
        end
    endgenerate

    assign h0_main = tap_bank[TAP_W-1:0];

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adapt_en && !load_en) |=> $stable(tap_bank)) else $error("freeze"); // R7

    AST_UNROLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (unroll_en && !load_en && (ui_odd == (dec_bit == hist[1]))) |=> $stable(tap_bank)) else $error("pattern hold"); // R9

endmodule

// File: tb/sslms_tap_adapt_test.sv
`timescale 1ns/1ps
module sslms_tap_adapt_test;

    localparam int NTAP   = 4;
    localparam int TAP_W  = 8;
    localparam int FRAC_W = 6;
    localparam int MU_W   = $clog2(FRAC_W + 1);
    localparam int AMAX   = (1 << (TAP_W + FRAC_W - 1)) - 1;
    localparam int AMIN   = -(1 << (TAP_W + FRAC_W - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adapt_en = 1'b0, load_en = 1'b0, unroll_en = 1'b0, ui_odd = 1'b0;
    logic dec_bit = 1'b0, err_pos_hi = 1'b0, err_neg_hi = 1'b0;
    logic [TAP_W-1:0] init_tap = '0;
    logic [MU_W-1:0]  mu_shift = '0;
    logic [(NTAP+1)*TAP_W-1:0] tap_bank;
    logic [TAP_W-1:0] h0_main;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int acc_m [0:NTAP];
    bit hist_m [1:NTAP];

    always #10 clk = ~clk;

    sslms_tap_adapt #(.NTAP(NTAP), .TAP_W(TAP_W), .FRAC_W(FRAC_W)) uut (
        .clk(clk), .rst_n(rst_n), .adapt_en(adapt_en), .load_en(load_en),
        .init_tap(init_tap), .mu_shift(mu_shift), .unroll_en(unroll_en),
        .ui_odd(ui_odd), .dec_bit(dec_bit), .err_pos_hi(err_pos_hi),
        .err_neg_hi(err_neg_hi), .tap_bank(tap_bank), .h0_main(h0_main)
    );

    function automatic int step_of(input int mu);
        int m = (mu > FRAC_W) ? FRAC_W : mu;
        return 1 << (FRAC_W - m);
    endfunction

    function automatic int clamp(input int v, input int lo);
        if (v > AMAX) return AMAX;
        if (v < lo) return lo;
        return v;
    endfunction

    // advance the reference model by one UI using the current inputs
    task automatic model_step();
        int st = step_of(int'(mu_shift));
        bit qual = !unroll_en || (ui_odd ? (dec_bit != hist_m[1]) : (dec_bit == hist_m[1]));
        bit es = dec_bit ? err_pos_hi : err_neg_hi;
        if (load_en) begin
            for (int n = 0; n <= NTAP; n++) begin
                acc_m[n] = int'($signed(init_tap)) * (1 << FRAC_W);
                if (n == 0 && acc_m[n] < 0) acc_m[n] = 0;
            end
        end else if (adapt_en && qual) begin
            for (int n = 0; n <= NTAP; n++) begin
                bit a = (n == 0) ? dec_bit : hist_m[n];
                acc_m[n] = clamp(acc_m[n] + ((es == a) ? st : -st), (n == 0) ? 0 : AMIN);
            end
        end
        for (int n = NTAP; n >= 2; n--) hist_m[n] = hist_m[n-1];
        hist_m[1] = dec_bit;
    endtask

    task automatic compare(input string req);
        bit bad = 1'b0;
        checks++;
        for (int n = 0; n <= NTAP; n++) begin
            int got = int'($signed(tap_bank[n*TAP_W +: TAP_W]));
            int exp = acc_m[n] >>> FRAC_W;
            if (!bad && got != exp) begin
                $display("FAIL %s tap%0d actual=%0d expected=%0d", req, n, got, exp);
                bad = 1'b1;
            end
        end
        if (!bad && h0_main != tap_bank[TAP_W-1:0]) begin
            $display("FAIL R10 h0_main actual=%0d expected=%0d",
                     $signed(h0_main), $signed(tap_bank[TAP_W-1:0]));
            bad = 1'b1;
        end
        if (bad) failures++;
    endtask

    // inputs set at the falling edge, result checked at the next falling edge
    task automatic tick(input string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    task automatic drive(input bit d, input bit ep, input bit en_n);
        dec_bit = d; err_pos_hi = ep; err_neg_hi = en_n;
    endtask

    task automatic rand_run(input int cycles, input bit unr, input string req);
        for (int i = 0; i < cycles; i++) begin
            if (i % 150 == 0) mu_shift = MU_W'($urandom_range(0, (1 << MU_W) - 1));
            drive($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
            adapt_en  = ($urandom_range(0, 9) != 0);
            load_en   = ($urandom_range(0, 299) == 0);
            init_tap  = TAP_W'($urandom);
            unroll_en = unr;
            ui_odd    = ~ui_odd;
            tick(req);
        end
        load_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int n = 0; n <= NTAP; n++) acc_m[n] = 0;
        for (int n = 1; n <= NTAP; n++) hist_m[n] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");

        // R1: history reset to -1, so an even unrolled UI with dec 0 qualifies
        adapt_en = 1'b1; unroll_en = 1'b1; ui_odd = 1'b0; mu_shift = 0;
        drive(1'b0, 1'b0, 1'b1);
        tick("R1 history reset");
        unroll_en = 1'b0;

        // R8: load and priority over enable
        load_en = 1'b1; init_tap = 8'd20;
        tick("R8 load");
        load_en = 1'b1; init_tap = 8'hFB;
        tick("R6 negative load floors h0");
        load_en = 1'b0;

        // R2: unused comparator ignored
        drive(1'b1, 1'b1, 1'b0); tick("R2 dec1 uses err_pos");
        drive(1'b1, 1'b1, 1'b1); tick("R2 err_neg ignored");
        drive(1'b0, 1'b1, 1'b0); tick("R2 dec0 uses err_neg");
        drive(1'b0, 1'b0, 1'b0); tick("R2 err_pos ignored");

        // R4: mu clamp beyond FRAC_W
        mu_shift = MU_W'(7);
        for (int i = 0; i < 70; i++) begin drive(1'b1, 1'b1, 1'b0); tick("R4 mu clamp"); end

        // R7: freeze
        adapt_en = 1'b0;
        for (int i = 0; i < 8; i++) begin drive(i[0], i[1], i[2]); tick("R7 freeze"); end
        adapt_en = 1'b1;

        // R5: positive saturation
        load_en = 1'b1; init_tap = 8'd127; tick("R8 load max");
        load_en = 1'b0; mu_shift = 0;
        for (int i = 0; i < 12; i++) begin drive(1'b1, 1'b1, 1'b0); tick("R5 saturate high"); end

        // R5/R6: negative saturation and h0 floor
        load_en = 1'b1; init_tap = 8'h80; tick("R8 load min");
        load_en = 1'b0;
        for (int i = 0; i < 12; i++) begin drive(1'b1, 1'b0, 1'b1); tick("R5 R6 saturate low"); end

        // R9: unrolled patterns, directed
        unroll_en = 1'b1; mu_shift = 2;
        for (int i = 0; i < 16; i++) begin
            ui_odd = i[0];
            drive(i[1], i[2], i[3]);
            tick("R9 pattern qualifier");
        end

        rand_run(3000, 1'b0, "R3 normal random");
        rand_run(3000, 1'b1, "R9 unrolled random");
        rand_run(1000, 1'b0, "R4 mixed mu");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule